// File: doc/BRIEF.md
# Static LCD Segment and Common Driver

This block produces the drive waveforms for a single-backplane liquid crystal panel from one system clock, nominally 32768 Hz. A free-running binary divider supplies a display clock and a blink clock, each picked from a small set of divider taps. The two common outputs carry the inverse of the display clock. Every segment output swings either against the commons (lit) or with them (dark), so a dark segment sees no net voltage.

Segment data arrives as a 40-bit word and is captured on a load strobe. Group disables hold the low 16 or the upper 24 segments at 0, and each common has its own disable. When blinking is enabled, lit segments go dark whenever the blink clock is high. The blink clock comes either from a divider tap or from an external input. All outputs are registered, so the panel always sees clean levels.

Top module: `static_lcd_drv`

## Requirements
- R1: While `rst` is high at a clock edge, the divider and the data register clear, and `seg_out`, `com_a` and `com_b` become 0.
- R2: The divider counts the edges since reset release, modulo 2^15. The outputs registered at an edge use the count c held before that edge. The display clock is bit (3+`disp_sel`) of c, giving periods of 16, 32, 64, 128 and 256 input cycles for `disp_sel` 0 to 4. Codes 5 to 7 act as 4.
- R3: When neither common is disabled, `com_a` and `com_b` both equal the inverse of the display clock.
- R4: A segment whose stored bit is 1 outputs the display clock, which is in antiphase with the commons. A segment whose stored bit is 0 outputs the inverse, which is in phase with them. Segment i is `seg_out[i]`, and stored bit i drives segment i.
- R5: When `seg_lo_off` is high, `seg_out[15:0]` are 0.
- R6: When `seg_hi_off` is high, `seg_out[39:16]` are 0.
- R7: When `com_a_off` is high, `com_a` is 0. When `com_b_off` is high, `com_b` is 0. Each disable acts only on its own common.
- R8: When `blink_off` is low and the blink clock is high, every segment is driven as if its stored bit were 0. When the blink clock is low, or `blink_off` is high, segments follow the stored data.
- R9: With `blink_ext_sel` low, the blink clock is bit (12+`blink_sel`) of the divider count c: 1/8192, 1/16384 and 1/32768 for codes 0 to 2, with code 3 acting as 2. With `blink_ext_sel` high, the blink clock is `blink_ext_clk`.
- R10: `seg_data` is captured only at an edge where `seg_load` is high. The new data first appears in the outputs registered at the following edge. Without a load, changes to `seg_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, nominally 32768 Hz |
| rst | input | 1 | Synchronous reset, active high |
| seg_data | input | 40 | Segment pattern, bit i for segment i, 1 = lit |
| seg_load | input | 1 | Capture strobe for `seg_data` |
| seg_lo_off | input | 1 | Forces segments 0 to 15 low |
| seg_hi_off | input | 1 | Forces segments 16 to 39 low |
| com_a_off | input | 1 | Forces `com_a` low |
| com_b_off | input | 1 | Forces `com_b` low |
| blink_off | input | 1 | Low enables blinking |
| disp_sel | input | 3 | Display clock tap select |
| blink_sel | input | 2 | Internal blink clock tap select |
| blink_ext_sel | input | 1 | Selects `blink_ext_clk` as the blink clock |
| blink_ext_clk | input | 1 | External blink clock |
| seg_out | output | 40 | Segment drive outputs |
| com_a | output | 1 | Common output A |
| com_b | output | 1 | Common output B |

## Verification
The bench sweeps every display tap, including the out-of-range codes, over many periods. A wrong tap or a missing clamp shows up as a shifted or stuck display clock on every output. It runs the internal blink taps across a full 1/32768 period, so an off-by-one tap would dim the panel at the wrong rate. It also checks that `blink_off` high suppresses blinking, which a design that inverts the enable would get wrong. The boundary between segments 15 and 16 is tested with each group disable on its own, which catches a misplaced group split. The load latency and the case of data changing without a strobe are checked too, which catches a design that passes `seg_data` straight through.

// File: rtl/static_lcd_drv.sv
module static_lcd_drv #(
  parameter int NSEG       = 40,
  parameter int LO_SEGS    = 16,
  parameter int DIV_W      = 15,
  parameter int DISP_BASE  = 3,
  parameter int BLINK_BASE = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSEG-1:0] seg_data,
  input  logic            seg_load,
  input  logic            seg_lo_off,
  input  logic            seg_hi_off,
  input  logic            com_a_off,
  input  logic            com_b_off,
  input  logic            blink_off,
  input  logic [2:0]      disp_sel,
  input  logic [1:0]      blink_sel,
  input  logic            blink_ext_sel,
  input  logic            blink_ext_clk,
  output logic [NSEG-1:0] seg_out,
  output logic            com_a,
  output logic            com_b
);
  localparam int DISP_MAX  = 4;
  localparam int BLINK_MAX = 2;

  logic [DIV_W-1:0] div_q;
  logic [NSEG-1:0]  data_q;
  logic [NSEG-1:0]  seg_nxt;
  logic [2:0]       dsel;
  logic [1:0]       bsel;
  logic [DIV_W-1:0] d_sh, b_sh;
  logic             dclk, bclk, gate;

  assign dsel = (disp_sel > 3'(DISP_MAX)) ? 3'(DISP_MAX) : disp_sel;
  assign bsel = (blink_sel > 2'(BLINK_MAX)) ? 2'(BLINK_MAX) : blink_sel;
  assign d_sh = div_q >> (DISP_BASE + int'(dsel));
  assign b_sh = div_q >> (BLINK_BASE + int'(bsel));
  assign dclk = d_sh[0];
  assign bclk = blink_ext_sel ? blink_ext_clk : b_sh[0];
  assign gate = !blink_off && bclk;

  always_comb begin
    for (int i = 0; i < NSEG; i++) begin
      seg_nxt[i] = ((data_q[i] && !gate) ? dclk : !dclk)
                   && !((i < LO_SEGS) ? seg_lo_off : seg_hi_off);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      data_q  <= '0;
      seg_out <= '0;
      com_a   <= 1'b0;
      com_b   <= 1'b0;
    end else begin
      div_q   <= div_q + 1'b1;
      if (seg_load) data_q <= seg_data;
      seg_out <= seg_nxt;
      com_a   <= !com_a_off && !dclk;
      com_b   <= !com_b_off && !dclk;
    end
  end

  AST_COMS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (!com_a_off && !com_b_off) |=> (com_a == com_b));  // R3
  AST_LIT_ANTI: assert property (@(posedge clk) disable iff (rst)
    (data_q[0] && !gate && !seg_lo_off && !com_a_off) |=> (seg_out[0] != com_a));  // R4
  AST_LO_OFF: assert property (@(posedge clk) disable iff (rst)
    seg_lo_off |=> (seg_out[LO_SEGS-1:0] == '0));  // R5
  AST_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    seg_hi_off |=> (seg_out[NSEG-1:LO_SEGS] == '0));  // R6
  AST_COMA_OFF: assert property (@(posedge clk) disable iff (rst)
    com_a_off |=> !com_a);  // R7
  AST_COMB_OFF: assert property (@(posedge clk) disable iff (rst)
    com_b_off |=> !com_b);  // R7
  AST_BLINK_DARK: assert property (@(posedge clk) disable iff (rst)
    (gate && !seg_lo_off && !com_a_off) |=> (seg_out[0] == com_a));  // R8
endmodule

// File: tb/static_lcd_drv_bench.sv
module static_lcd_drv_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [39:0] seg_data = '0;
  logic        seg_load = 1'b0;
  logic        seg_lo_off = 1'b0, seg_hi_off = 1'b0;
  logic        com_a_off = 1'b0, com_b_off = 1'b0;
  logic        blink_off = 1'b1;
  logic [2:0]  disp_sel = '0;
  logic [1:0]  blink_sel = '0;
  logic        blink_ext_sel = 1'b0, blink_ext_clk = 1'b0;
  logic [39:0] seg_out;
  logic        com_a, com_b;

  int errs = 0, checks = 0, n = 0;
  logic [39:0] data_m = '0;

  static_lcd_drv u_static_lcd_drv (
    .clk(clk), .rst(rst), .seg_data(seg_data), .seg_load(seg_load),
    .seg_lo_off(seg_lo_off), .seg_hi_off(seg_hi_off),
    .com_a_off(com_a_off), .com_b_off(com_b_off), .blink_off(blink_off),
    .disp_sel(disp_sel), .blink_sel(blink_sel),
    .blink_ext_sel(blink_ext_sel), .blink_ext_clk(blink_ext_clk),
    .seg_out(seg_out), .com_a(com_a), .com_b(com_b));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) n <= rst ? 0 : n + 1;

  function automatic logic dclk_m();
    int c = (n - 1) & 32'h7FFF;
    int s = (disp_sel > 4) ? 4 : int'(disp_sel);
    return logic'((c >> (3 + s)) & 1);
  endfunction

  function automatic logic bclk_m();
    int c = (n - 1) & 32'h7FFF;
    int s = (blink_sel > 2) ? 2 : int'(blink_sel);
    if (blink_ext_sel) return blink_ext_clk;
    return logic'((c >> (12 + s)) & 1);
  endfunction

  function automatic logic [39:0] seg_m(input logic [39:0] d);
    logic [39:0] v;
    logic dc = dclk_m();
    logic g = !blink_off && bclk_m();
    for (int i = 0; i < 40; i++) begin
      v[i] = (d[i] && !g) ? dc : !dc;
      if (i < 16 && seg_lo_off) v[i] = 1'b0;
      if (i >= 16 && seg_hi_off) v[i] = 1'b0;
    end
    return v;
  endfunction

  task automatic check(input string req, input logic [39:0] es, input logic ea, input logic eb);
    checks++;
    if (seg_out !== es || com_a !== ea || com_b !== eb) begin
      errs++;
      $display("FAIL %s: n=%0d seg=%h com=%b%b expected seg=%h com=%b%b",
               req, n, seg_out, com_a, com_b, es, ea, eb);
    end
  endtask

  task automatic check_model(input string req);
    logic dc = dclk_m();
    check(req, seg_m(data_m), !com_a_off && !dc, !com_b_off && !dc);
  endtask

  task automatic load(input logic [39:0] d);
    @(negedge clk); seg_data = d; seg_load = 1'b1;
    @(negedge clk); seg_load = 1'b0; data_m = d;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", '0, 1'b0, 1'b0);
    rst = 1'b0;
    data_m = '0;
    repeat (40) begin @(negedge clk); check_model("R1"); end
  endtask

  task automatic t_disp_taps();
    load(40'hA5_5A3C_F00F);
    for (int s = 0; s < 8; s++) begin
      @(negedge clk); disp_sel = 3'(s);
      repeat (600) begin @(negedge clk); check_model("R2"); end
    end
    disp_sel = 3'd0;
    load(40'hFF_FFFF_FFFF);
    repeat (64) begin @(negedge clk); check_model("R4"); end
    repeat (64) begin @(negedge clk); check_model("R3"); end
  endtask

  task automatic t_disables();
    load(40'hFF_FFFF_FFFF);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      {seg_lo_off, seg_hi_off, com_a_off, com_b_off} = 4'(k);
      repeat (40) begin
        @(negedge clk);
        if (k[3] || k[2]) check_model(k[3] ? "R5" : "R6");
        else check_model("R7");
      end
    end
    @(negedge clk);
    {seg_lo_off, seg_hi_off, com_a_off, com_b_off} = '0;
  endtask

  task automatic t_blink_int();
    load(40'h0F_F0F0_3C3C);
    disp_sel = 3'd1;
    @(negedge clk); blink_off = 1'b0;
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); blink_sel = 2'(s);
      repeat ((s == 0) ? 9000 : (s == 1) ? 17000 : 33000) begin
        @(negedge clk);
        if ((n & 15) == 3) check_model((s == 0) ? "R8" : "R9");
      end
    end
    @(negedge clk); blink_off = 1'b1; blink_sel = 2'd0;
    repeat (9000) begin
      @(negedge clk);
      if ((n & 31) == 7) check_model("R8");
    end
  endtask

  task automatic t_blink_ext();
    @(negedge clk); blink_ext_sel = 1'b1; blink_off = 1'b0; blink_sel = 2'd2;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); blink_ext_clk = k[0];
      repeat (20) begin @(negedge clk); check_model("R9"); end
    end
    @(negedge clk); blink_ext_sel = 1'b0; blink_off = 1'b1; blink_ext_clk = 1'b0;
  endtask

  task automatic t_load();
    logic [39:0] old;
    load(40'h12_3456_789A);
    repeat (20) begin @(negedge clk); check_model("R10"); end
    @(negedge clk); seg_data = 40'hED_CBA9_8765;
    repeat (40) begin @(negedge clk); check_model("R10"); end
    old = data_m;
    @(negedge clk); seg_data = 40'h00_FFFF_0000; seg_load = 1'b1;
    @(negedge clk); seg_load = 1'b0;
    check("R10", seg_m(old), !dclk_m(), !dclk_m());
    data_m = 40'h00_FFFF_0000;
    repeat (40) begin @(negedge clk); check_model("R10"); end
  endtask

  initial begin
    t_reset();
    t_disp_taps();
    t_disables();
    t_blink_int();
    t_blink_ext();
    t_load();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 190000);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule